// File: doc/BRIEF.md
# Layered Alpha Compositor

The block builds a raster image by stacking up to four pixel layers on top of a constant, fully opaque background colour. It scans the output frame itself, one pixel per clock. A layer whose placement rectangle covers the current pixel is asked for its next pixel through a per-layer take strobe. Each layer then goes through its own blend stage. Stage 0 receives the background as its destination, and every stage passes its result on as the destination of the next stage, so layer 0 lies at the bottom and the last layer at the top.

Pixels are 32 bits wide, with alpha in bits [31:24] and three 8-bit colour channels in [23:16], [15:8] and [7:0]. The same arithmetic is applied whether the channels hold RGB or YUV. A layer is either straight-alpha or premultiplied, and a disabled stage hands its destination on untouched. Configuration is written into a shadow bank through a simple write port. A frame request copies that bank into the working set, clamping the values as it does so. A write that lands mid-frame therefore only affects the next frame.

The scan controller has four states. IDLE waits for a request. LOAD copies the configuration. SCAN walks the raster. DRAIN waits out the blend pipeline. The transitions are: IDLE→LOAD on `frame_go`, LOAD→SCAN always, SCAN→DRAIN on the last pixel of the frame, and DRAIN→IDLE after NUM_LAYERS cycles.

Top module: `ccomp_top`

## Requirements
- R1: After reset `out_valid`, `frame_busy` and `lyr_take` are 0, the background colour is 0, every layer is disabled and the frame is 1x1. A frame run in this state yields the single pixel 0xFF000000.
- R2: For a straight-alpha layer, each colour channel becomes sat(m(D,255−Sa) + m(S,Sa)) and alpha becomes sat(m(Da,255−Sa) + Sa). Here m(a,b) is a·b/255 rounded to nearest, and sat limits the result to 255.
- R3: For a premultiplied layer (bit 31 of the size word), each colour channel becomes sat(m(D,255−Sa) + S), and alpha uses the R2 formula.
- R4: The background {0xFF, colour} is the destination of stage 0. Layer k feeds stage k, and the result of stage k is the destination of stage k+1.
- R5: When a layer is disabled (bit 30 of its size word is 0), its take strobe stays low and its stage passes the destination through unchanged.
- R6: A layer is taken and blended only when the pixel lies within left ≤ x < left+w and top ≤ y < top+h. Elsewhere, including where the rectangle runs past the frame edge, its stage passes the destination through.
- R7: At frame start, a layer's left offset is clamped to at most width−1 and its top offset to at most height−1.
- R8: Frame and layer width and height written as 0 become 1, and values above 8190 become 8190.
- R9: A frame produces exactly width·height output pixels in raster order. `out_sof` marks the first pixel and `out_eol` marks the last pixel of every line.
- R10: Configuration written while a frame is in progress has no effect on that frame and takes effect at the next frame request.
- R11: `frame_go` is ignored while `frame_busy` is high, and `out_valid` is low whenever `frame_busy` is low.
- R12: The first output pixel appears NUM_LAYERS+1 rising edges after the edge that samples `frame_go`.

Register words (`cfg_addr`): 0 holds width in [12:0] and height in [28:16]. 1 holds the background colour in [23:0]. 2+2k holds the layer k left offset in [12:0] and top offset in [28:16]. 3+2k holds the layer k width in [12:0], height in [28:16], enable in [30] and premultiplied in [31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| frame_go | input | 1 | Frame request pulse |
| frame_busy | output | 1 | Frame in progress, including pipeline drain |
| lyr_pix | input | 32·NUM_LAYERS | Current pixel offered by each layer (layer k at [32k+31:32k]) |
| lyr_take | output | NUM_LAYERS | Layer k pixel is consumed at the next edge |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | First pixel of the frame |
| out_eol | output | 1 | Last pixel of a line |
| out_pix | output | 32 | Composited pixel |

## Verification
Two functions can fall in the same cycle. A configuration write can arrive while a frame is streaming, and a new frame request can arrive while the scan or drain is still running. The bench forces the first case by rewriting the background and the enable of layer 0 a few cycles after a request. It then requires every pixel of the running frame to match the model built from the old settings, and the next frame to match the new ones. It forces the second case by pulsing `frame_go` in the middle of a frame. It then requires exactly one frame's worth of pixels, no pixels after `frame_busy` falls, and unchanged take counts.

// File: rtl/ccomp_pkg.sv
package ccomp_pkg;

    localparam int DIM_W   = 13;
    localparam int MAX_DIM = 8190;
    localparam int PIX_W   = 32;

    typedef logic [DIM_W-1:0] dim_t;
    typedef logic [PIX_W-1:0] pix_t;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_LOAD  = 2'd1,
        RS_SCAN  = 2'd2,
        RS_DRAIN = 2'd3
    } rstate_e;

    // a*b/255 rounded to nearest, exact for 8-bit operands
    function automatic logic [7:0] frac_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        logic [15:0] q;
        p = 16'(a) * 16'(b) + 16'd128;
        q = (p + (p >> 8)) >> 8;
        return q[7:0];
    endfunction

    function automatic logic [7:0] sat_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[8] ? 8'hFF : s[7:0];
    endfunction

    function automatic dim_t clamp_dim(input dim_t v);
        if (v == '0)
            return dim_t'(1);
        else if (v > dim_t'(MAX_DIM))
            return dim_t'(MAX_DIM);
        else
            return v;
    endfunction

endpackage

// File: rtl/ccomp_cfg.sv
module ccomp_cfg
    import ccomp_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              load,
    output dim_t              act_w,
    output dim_t              act_h,
    output logic [23:0]       act_bg,
    output logic              act_en   [NUM_LAYERS],
    output logic              act_pm   [NUM_LAYERS],
    output dim_t              act_left [NUM_LAYERS],
    output dim_t              act_top  [NUM_LAYERS],
    output dim_t              act_lw   [NUM_LAYERS],
    output dim_t              act_lh   [NUM_LAYERS]
);

    localparam int FRAME_ADDR = 0;
    localparam int BG_ADDR    = 1;
    localparam int LYR_BASE   = 2;

    logic [31:0] sh_frame;
    logic [23:0] sh_bg;
    logic [31:0] sh_pos  [NUM_LAYERS];
    logic [31:0] sh_size [NUM_LAYERS];

    dim_t new_w, new_h;

    // Shadow bank: written any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_frame <= {3'b0, 13'd1, 3'b0, 13'd1};
            sh_bg    <= '0;
            for (int i = 0; i < NUM_LAYERS; i++) begin
                sh_pos[i]  <= '0;
                sh_size[i] <= {3'b0, 13'd1, 3'b0, 13'd1};
            end
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(FRAME_ADDR)) sh_frame <= cfg_wdata;
            if (cfg_addr == ADDR_W'(BG_ADDR))    sh_bg    <= cfg_wdata[23:0];
            for (int i = 0; i < NUM_LAYERS; i++) begin
                if (cfg_addr == ADDR_W'(LYR_BASE + 2 * i))     sh_pos[i]  <= cfg_wdata;
                if (cfg_addr == ADDR_W'(LYR_BASE + 2 * i + 1)) sh_size[i] <= cfg_wdata;
            end
        end
    end

    assign new_w = clamp_dim(sh_frame[DIM_W-1:0]);
    assign new_h = clamp_dim(sh_frame[16 +: DIM_W]);

    // Working set: copied with clamping at frame start only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_w  <= dim_t'(1);
            act_h  <= dim_t'(1);
            act_bg <= '0;
            for (int i = 0; i < NUM_LAYERS; i++) begin
                act_en[i]   <= 1'b0;
                act_pm[i]   <= 1'b0;
                act_left[i] <= '0;
                act_top[i]  <= '0;
                act_lw[i]   <= dim_t'(1);
                act_lh[i]   <= dim_t'(1);
            end
        end else if (load) begin
            act_w  <= new_w;
            act_h  <= new_h;
            act_bg <= sh_bg;
            for (int i = 0; i < NUM_LAYERS; i++) begin
                act_en[i]   <= sh_size[i][30];
                act_pm[i]   <= sh_size[i][31];
                act_left[i] <= (sh_pos[i][DIM_W-1:0] > new_w - dim_t'(1)) ?
                               new_w - dim_t'(1) : sh_pos[i][DIM_W-1:0];
                act_top[i]  <= (sh_pos[i][16 +: DIM_W] > new_h - dim_t'(1)) ?
                               new_h - dim_t'(1) : sh_pos[i][16 +: DIM_W];
                act_lw[i]   <= clamp_dim(sh_size[i][DIM_W-1:0]);
                act_lh[i]   <= clamp_dim(sh_size[i][16 +: DIM_W]);
            end
        end
    end

endmodule

// File: rtl/ccomp_raster.sv
module ccomp_raster
    import ccomp_pkg::*;
#(
    parameter int NUM_LAYERS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_go,
    input  dim_t act_w,
    input  dim_t act_h,
    output logic load,
    output logic busy,
    output logic scan_valid,
    output logic scan_sof,
    output logic scan_eol,
    output dim_t scan_x,
    output dim_t scan_y
);

    localparam int DRN_W = $clog2(NUM_LAYERS + 1);

    rstate_e          state_q, state_d;
    dim_t             x_q, y_q;
    logic [DRN_W-1:0] drain_q;
    logic             row_end, last_px, drain_done;

    assign row_end    = (x_q == act_w - dim_t'(1));
    assign last_px    = row_end && (y_q == act_h - dim_t'(1));
    assign drain_done = (drain_q == DRN_W'(NUM_LAYERS - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (frame_go)   state_d = RS_LOAD;
            RS_LOAD:                  state_d = RS_SCAN;
            RS_SCAN:  if (last_px)    state_d = RS_DRAIN;
            RS_DRAIN: if (drain_done) state_d = RS_IDLE;
            default:                  state_d = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Raster and drain counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            drain_q <= '0;
        end else begin
            unique case (state_q)
                RS_LOAD: begin
                    x_q     <= '0;
                    y_q     <= '0;
                    drain_q <= '0;
                end
                RS_SCAN: begin
                    if (row_end) begin
                        x_q <= '0;
                        if (!last_px) y_q <= y_q + dim_t'(1);
                    end else begin
                        x_q <= x_q + dim_t'(1);
                    end
                end
                RS_DRAIN: drain_q <= drain_q + DRN_W'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        load       = 1'b0;
        busy       = 1'b1;
        scan_valid = 1'b0;
        unique case (state_q)
            RS_IDLE:  busy       = 1'b0;
            RS_LOAD:  load       = 1'b1;
            RS_SCAN:  scan_valid = 1'b1;
            RS_DRAIN: ;
            default:  busy       = 1'b0;
        endcase
    end

    assign scan_sof = scan_valid && (x_q == '0) && (y_q == '0);
    assign scan_eol = scan_valid && row_end;
    assign scan_x   = x_q;
    assign scan_y   = y_q;

endmodule

// File: rtl/ccomp_stage.sv
module ccomp_stage
    import ccomp_pkg::*;
#(
    parameter int SRC_DLY = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic premul,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eol,
    input  pix_t in_pix,
    input  pix_t src_pix,
    input  logic src_use,
    output logic out_valid,
    output logic out_sof,
    output logic out_eol,
    output pix_t out_pix
);

    pix_t       d_pix;
    logic       d_use;
    pix_t       mixed;
    logic [7:0] sa, ia;

    // Align the layer pixel with the destination arriving from earlier stages
    generate
        if (SRC_DLY == 0) begin : g_nodly
            assign d_pix = src_pix;
            assign d_use = src_use;
        end else begin : g_dly
            pix_t               pix_sr [SRC_DLY];
            logic [SRC_DLY-1:0] use_sr;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    use_sr <= '0;
                    for (int j = 0; j < SRC_DLY; j++) pix_sr[j] <= '0;
                end else begin
                    use_sr[0] <= src_use;
                    pix_sr[0] <= src_pix;
                    for (int j = 1; j < SRC_DLY; j++) begin
                        use_sr[j] <= use_sr[j-1];
                        pix_sr[j] <= pix_sr[j-1];
                    end
                end
            end
            assign d_pix = pix_sr[SRC_DLY-1];
            assign d_use = use_sr[SRC_DLY-1];
        end
    endgenerate

    assign sa = d_pix[31:24];
    assign ia = 8'hFF - sa;

    always_comb begin
        pix_t res;
        res[31:24] = sat_add(frac_mul(in_pix[31:24], ia), sa);
        for (int c = 0; c < 3; c++) begin
            res[8*c +: 8] = sat_add(frac_mul(in_pix[8*c +: 8], ia),
                                    premul ? d_pix[8*c +: 8] : frac_mul(d_pix[8*c +: 8], sa));
        end
        mixed = d_use ? res : in_pix;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eol   <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_sof;
            out_eol   <= in_eol;
            out_pix   <= mixed;
        end
    end

endmodule

// File: rtl/ccomp_top.sv
module ccomp_top
    import ccomp_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int ADDR_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [31:0]                 cfg_wdata,
    input  logic                        frame_go,
    output logic                        frame_busy,
    input  logic [NUM_LAYERS*32-1:0]    lyr_pix,
    output logic [NUM_LAYERS-1:0]       lyr_take,
    output logic                        out_valid,
    output logic                        out_sof,
    output logic                        out_eol,
    output logic [31:0]                 out_pix
);

    logic        load;
    dim_t        act_w, act_h;
    logic [23:0] act_bg;
    logic        act_en   [NUM_LAYERS];
    logic        act_pm   [NUM_LAYERS];
    dim_t        act_left [NUM_LAYERS];
    dim_t        act_top  [NUM_LAYERS];
    dim_t        act_lw   [NUM_LAYERS];
    dim_t        act_lh   [NUM_LAYERS];

    logic scan_valid, scan_sof, scan_eol;
    dim_t scan_x, scan_y;

    logic ch_valid [NUM_LAYERS+1];
    logic ch_sof   [NUM_LAYERS+1];
    logic ch_eol   [NUM_LAYERS+1];
    pix_t ch_pix   [NUM_LAYERS+1];

    ccomp_cfg #(.NUM_LAYERS(NUM_LAYERS), .ADDR_W(ADDR_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .load     (load),
        .act_w    (act_w),
        .act_h    (act_h),
        .act_bg   (act_bg),
        .act_en   (act_en),
        .act_pm   (act_pm),
        .act_left (act_left),
        .act_top  (act_top),
        .act_lw   (act_lw),
        .act_lh   (act_lh)
    );

    ccomp_raster #(.NUM_LAYERS(NUM_LAYERS)) raster_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_go  (frame_go),
        .act_w     (act_w),
        .act_h     (act_h),
        .load      (load),
        .busy      (frame_busy),
        .scan_valid(scan_valid),
        .scan_sof  (scan_sof),
        .scan_eol  (scan_eol),
        .scan_x    (scan_x),
        .scan_y    (scan_y)
    );

    // Background layer feeds the bottom of the chain
    assign ch_valid[0] = scan_valid;
    assign ch_sof[0]   = scan_sof;
    assign ch_eol[0]   = scan_eol;
    assign ch_pix[0]   = {8'hFF, act_bg};

    generate
        for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_layer
            logic [DIM_W:0] x_end, y_end;
            logic           hit;

            assign x_end = {1'b0, act_left[k]} + {1'b0, act_lw[k]};
            assign y_end = {1'b0, act_top[k]}  + {1'b0, act_lh[k]};
            assign hit   = act_en[k]
                        && (scan_x >= act_left[k]) && ({1'b0, scan_x} < x_end)
                        && (scan_y >= act_top[k])  && ({1'b0, scan_y} < y_end);
            assign lyr_take[k] = scan_valid && hit;

            ccomp_stage #(.SRC_DLY(k)) stage_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .premul   (act_pm[k]),
                .in_valid (ch_valid[k]),
                .in_sof   (ch_sof[k]),
                .in_eol   (ch_eol[k]),
                .in_pix   (ch_pix[k]),
                .src_pix  (lyr_pix[32*k +: 32]),
                .src_use  (lyr_take[k]),
                .out_valid(ch_valid[k+1]),
                .out_sof  (ch_sof[k+1]),
                .out_eol  (ch_eol[k+1]),
                .out_pix  (ch_pix[k+1])
            );
        end
    endgenerate

    assign out_valid = ch_valid[NUM_LAYERS];
    assign out_sof   = ch_sof[NUM_LAYERS];
    assign out_eol   = ch_eol[NUM_LAYERS];
    assign out_pix   = ch_pix[NUM_LAYERS];

endmodule

// File: rtl/ccomp_chk.sv
module ccomp_chk
    import ccomp_pkg::*;
#(
    parameter int NUM_LAYERS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  frame_busy,
    input logic                  out_valid,
    input logic                  out_sof,
    input logic                  out_eol,
    input logic [NUM_LAYERS-1:0] lyr_take,
    input logic                  act_en   [NUM_LAYERS],
    input dim_t                  act_left [NUM_LAYERS],
    input dim_t                  act_top  [NUM_LAYERS],
    input dim_t                  act_w,
    input dim_t                  act_h
);

    a_r9_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    a_r9_eol_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_eol |-> out_valid);

    a_r9_sof_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |=> !out_sof);

    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_busy |-> !out_valid);

    a_r11_take_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_busy |-> (lyr_take == '0));

    a_r8_frame_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_w != '0) && (act_h != '0) && (act_w <= dim_t'(MAX_DIM)) && (act_h <= dim_t'(MAX_DIM)));

    generate
        for (genvar k = 0; k < NUM_LAYERS; k++) begin : g_chk
            a_r5_take_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
                lyr_take[k] |-> act_en[k]);

            a_r7_origin_inside: assert property (@(posedge clk) disable iff (!rst_n)
                frame_busy |-> ((act_left[k] < act_w) && (act_top[k] < act_h)));
        end
    endgenerate

endmodule

bind ccomp_top ccomp_chk #(.NUM_LAYERS(NUM_LAYERS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_busy(frame_busy),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eol   (out_eol),
    .lyr_take  (lyr_take),
    .act_en    (act_en),
    .act_left  (act_left),
    .act_top   (act_top),
    .act_w     (act_w),
    .act_h     (act_h)
);

// File: tb/ccomp_top_tb_top.sv
`timescale 1ns/1ps
module ccomp_top_tb_top;

    localparam int NL = 4;
    localparam int AW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [AW-1:0]     cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic              frame_go = 1'b0;
    logic              frame_busy;
    logic [NL*32-1:0]  lyr_pix;
    logic [NL-1:0]     lyr_take;
    logic              out_valid, out_sof, out_eol;
    logic [31:0]       out_pix;

    always #2.5 clk = ~clk;

    ccomp_top #(.NUM_LAYERS(NL), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_go(frame_go), .frame_busy(frame_busy),
        .lyr_pix(lyr_pix), .lyr_take(lyr_take), .out_valid(out_valid),
        .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int first_cyc = -1;
    string tag = "R1";

    // configuration mirror (raw values as written)
    int m_w = 1, m_h = 1, m_bg = 0;
    int m_left [NL], m_top [NL], m_lw [NL], m_lh [NL];
    bit m_en [NL], m_pm [NL];
    int amode [NL];
    int seed = 0;

    int tcnt [NL];
    bit seen [NL];
    int base [NL];
    int exp_take [NL];
    logic [33:0] exp_q [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pgen(int k, int n, int sd, int md);
        logic [31:0] v;
        v = (32'(n) + 32'd1) * 32'h9E3779B1 ^ (32'(k) + 32'd1) * 32'h85EBCA6B ^ 32'(sd) * 32'hC2B2AE35;
        v = v ^ (v >> 13);
        v = v * 32'h27D4EB2D;
        v = v ^ (v >> 16);
        if (md == 1) v[31:24] = 8'hFF;
        if (md == 2) v[31:24] = 8'h00;
        return v;
    endfunction

    always_comb begin
        for (int k = 0; k < NL; k++) lyr_pix[32*k +: 32] = pgen(k, tcnt[k], seed, amode[k]);
    end

    function automatic int mm(int a, int b);
        return (a * b * 2 + 255) / 510;
    endfunction

    function automatic int lim(int v);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int cl(int v);
        if (v == 0) return 1;
        if (v > 8190) return 8190;
        return v;
    endfunction

    // monitor: layer consumption and output comparison
    always @(negedge clk) begin
        for (int k = 0; k < NL; k++) begin
            if (seen[k]) tcnt[k] = tcnt[k] + 1;
            seen[k] = lyr_take[k];
        end
        if (rst_n && out_valid) begin
            logic [33:0] e;
            if (first_cyc < 0) first_cyc = cyc;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s R9 extra pixel: got %h expected none", tag, out_pix);
            end else begin
                e = exp_q.pop_front();
                if ({out_pix, out_sof, out_eol} !== e) begin
                    fails++;
                    $display("FAIL %s pixel/markers: got %h sof=%0b eol=%0b expected %h sof=%0b eol=%0b",
                             tag, out_pix, out_sof, out_eol, e[33:2], e[1], e[0]);
                end
            end
        end
    end

    task automatic check(string t, bit ok, int got, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    task automatic cfg_write(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_frame(int w, int h);
        m_w = w & 8191; m_h = h & 8191;
        cfg_write(0, {3'b0, 13'(h), 3'b0, 13'(w)});
    endtask

    task automatic set_bg(int c);
        m_bg = c & 24'hFFFFFF;
        cfg_write(1, 32'(m_bg));
    endtask

    task automatic set_layer(int k, bit en, bit pm, int l, int t, int w, int h, int md);
        m_en[k] = en; m_pm[k] = pm; m_left[k] = l & 8191; m_top[k] = t & 8191;
        m_lw[k] = w & 8191; m_lh[k] = h & 8191; amode[k] = md;
        cfg_write(2 + 2 * k, {3'b0, 13'(t), 3'b0, 13'(l)});
        cfg_write(3 + 2 * k, {pm, en, 1'b0, 13'(h), 3'b0, 13'(w)});
    endtask

    // behavioural model of one frame from the mirrored settings (R2..R9)
    task automatic build_expected();
        int fw, fh;
        int l [NL], t [NL], lw [NL], lh [NL], idx [NL];
        fw = cl(m_w); fh = cl(m_h);
        for (int k = 0; k < NL; k++) begin
            lw[k] = cl(m_lw[k]); lh[k] = cl(m_lh[k]);
            l[k] = (m_left[k] > fw - 1) ? fw - 1 : m_left[k];
            t[k] = (m_top[k]  > fh - 1) ? fh - 1 : m_top[k];
            idx[k] = 0;
            base[k] = tcnt[k];
        end
        for (int y = 0; y < fh; y++) begin
            for (int x = 0; x < fw; x++) begin
                int da, dc [3];
                logic [31:0] s, r;
                da = 255;
                for (int c = 0; c < 3; c++) dc[c] = (m_bg >> (8 * c)) & 255;
                for (int k = 0; k < NL; k++) begin
                    if (m_en[k] && x >= l[k] && x < l[k] + lw[k] && y >= t[k] && y < t[k] + lh[k]) begin
                        int sa;
                        s = pgen(k, base[k] + idx[k], seed, amode[k]);
                        idx[k]++;
                        sa = int'(s[31:24]);
                        for (int c = 0; c < 3; c++) begin
                            int sc;
                            sc = int'(s[8*c +: 8]);
                            dc[c] = lim(mm(dc[c], 255 - sa) + (m_pm[k] ? sc : mm(sc, sa)));
                        end
                        da = lim(mm(da, 255 - sa) + sa);
                    end
                end
                r = {8'(da), 8'(dc[2]), 8'(dc[1]), 8'(dc[0])};
                exp_q.push_back({r, (x == 0 && y == 0), (x == fw - 1)});
            end
        end
        for (int k = 0; k < NL; k++) exp_take[k] = idx[k];
    endtask

    task automatic run_frame(string t, bit mid_change, bit extra_go);
        int go_cyc, n;
        tag = t;
        seed++;
        exp_q.delete();
        build_expected();
        first_cyc = -1;
        @(negedge clk);
        frame_go = 1'b1;
        @(posedge clk);
        #1 go_cyc = cyc;
        @(negedge clk);
        frame_go = 1'b0;
        if (mid_change) begin
            // R10: these writes must not reach the frame in flight
            repeat (3) @(negedge clk);
            set_bg(24'h5A17C3);
            set_layer(0, 1'b0, 1'b0, m_left[0], m_top[0], m_lw[0], m_lh[0], amode[0]);
        end
        if (extra_go) begin
            // R11: request while busy is ignored
            repeat (5) @(negedge clk);
            frame_go = 1'b1;
            @(negedge clk);
            frame_go = 1'b0;
        end
        n = 0;
        while (frame_busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (10) @(negedge clk);
        check({t, " R9 all pixels emitted"}, exp_q.size() == 0, exp_q.size(), 0);
        check({t, " R11 idle after frame"}, !frame_busy, int'(frame_busy), 0);
        check({t, " R12 first pixel latency"}, first_cyc == go_cyc + NL + 1,
              first_cyc - go_cyc, NL + 1);
        for (int k = 0; k < NL; k++)
            check({t, " R6 layer take count"}, tcnt[k] - base[k] == exp_take[k],
                  tcnt[k] - base[k], exp_take[k]);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NL; k++) begin
            m_left[k] = 0; m_top[k] = 0; m_lw[k] = 1; m_lh[k] = 1;
            m_en[k] = 0; m_pm[k] = 0; amode[k] = 0; tcnt[k] = 0; seen[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1 out_valid after reset", out_valid == 1'b0, int'(out_valid), 0);
        check("R1 frame_busy after reset", frame_busy == 1'b0, int'(frame_busy), 0);
        check("R1 lyr_take after reset", lyr_take == '0, int'(lyr_take), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame("R1", 1'b0, 1'b0);

        // R2: one straight-alpha layer, partially placed
        set_frame(16, 6);
        set_bg(24'h204080);
        set_layer(0, 1'b1, 1'b0, 3, 2, 8, 3, 0);
        run_frame("R2", 1'b0, 1'b0);

        // R3: premultiplied layer over a straight one
        set_layer(1, 1'b1, 1'b1, 2, 1, 10, 4, 0);
        run_frame("R3", 1'b0, 1'b0);

        // R4: all layers opaque and full frame -> top layer wins
        for (int k = 0; k < NL; k++) set_layer(k, 1'b1, k == 2, 0, 0, 16, 6, 1);
        run_frame("R4", 1'b0, 1'b0);
        // R4: all layers transparent -> background shows
        for (int k = 0; k < NL; k++) set_layer(k, 1'b1, 1'b0, 0, 0, 16, 6, 2);
        run_frame("R4", 1'b0, 1'b0);

        // R5: layers 1 and 3 disabled
        set_layer(0, 1'b1, 1'b0, 1, 1, 12, 4, 0);
        set_layer(1, 1'b0, 1'b0, 0, 0, 16, 6, 1);
        set_layer(2, 1'b1, 1'b1, 4, 0, 6, 6, 0);
        set_layer(3, 1'b0, 1'b1, 0, 0, 16, 6, 1);
        run_frame("R5", 1'b0, 1'b0);

        // R6/R7: offsets at and beyond the edges, rectangles clipped
        set_frame(20, 5);
        set_layer(0, 1'b1, 1'b0, 30, 2, 6, 2, 0);
        set_layer(1, 1'b1, 1'b1, 15, 4, 10, 10, 0);
        set_layer(2, 1'b1, 1'b0, 5, 9, 4, 3, 1);
        set_layer(3, 1'b1, 1'b0, 0, 0, 3, 2, 0);
        run_frame("R7", 1'b0, 1'b0);
        set_layer(0, 1'b1, 1'b0, 19, 0, 0, 0, 1);
        run_frame("R6", 1'b0, 1'b0);

        // R8: zero sizes become 1, oversize becomes 8190
        set_frame(0, 0);
        set_layer(0, 1'b1, 1'b0, 0, 0, 4, 4, 0);
        run_frame("R8", 1'b0, 1'b0);
        set_frame(8191, 1);
        set_layer(0, 1'b1, 1'b0, 8189, 0, 8191, 1, 0);
        set_layer(1, 1'b1, 1'b0, 0, 0, 0, 0, 0);
        run_frame("R8", 1'b0, 1'b0);

        // R10: writes during a frame land in the next one
        set_frame(12, 4);
        set_bg(24'h0F0F0F);
        for (int k = 0; k < NL; k++) set_layer(k, 1'b1, k[0], k, k, 6, 3, 0);
        run_frame("R10", 1'b1, 1'b0);
        run_frame("R10", 1'b0, 1'b0);

        // R11: extra request in the middle of a frame
        run_frame("R11", 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        check("R11 no second frame started", !frame_busy, int'(frame_busy), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule